// File: doc/BRIEF.md
# Two-wire serial memory slave front-end

This block is the bus-facing half of a byte-addressed serial memory that sits on a two-wire (I2C-style) bus. It samples the clock and data lines, finds start and stop conditions, and takes in the first byte of every transfer. That byte carries a device type code, three device select bits and a direction bit. When the type code and select bits match the block's strap pins, the slave takes part in the transfer. Otherwise it keeps silent until the next start.

A write-type transfer loads a 14-bit address counter from two word-address bytes and then stores each following data byte. Read-type transfers return bytes from wherever the counter points. The counter is shown to the storage array as a page field and a byte-within-page field. The storage array is outside this block. It sees a one-cycle write strobe with data, and a one-cycle read strobe whose data it returns on `mem_rdata` one clock later. The bus data line is open-drain, so the block only ever drives an active-high pull-down enable. There is no back-pressure anywhere: the array must accept every strobe, because bus bit times are many system clocks long.

Top module: `twslv_top`

## Requirements
- R1: A start (data falling while the clock is high) restarts address-byte reception from any state. A stop (data rising while the clock is high) sends the block to standby with `sda_oe` low. A word address cut short by a stop leaves the counter unchanged.
- R2: The first byte after a start is only acknowledged when its bits 7..4 equal 1010. On a mismatch `sda_oe` stays low in the ninth clock, and later bytes are ignored until the next start.
- R3: Bits 3..1 of the first byte must equal `sel_i[2:0]` for an acknowledge.
- R4: An accepted byte is acknowledged by holding `sda_oe` high from the clock fall after its eighth bit to the fall ending the ninth clock. After that fall, `sda_oe` is low again on a write path.
- R5: Bit 0 of the first byte selects the direction, 1 for read and 0 for write. On a write, the next byte's bits 5..0 become address bits 13..8 and its bits 7..6 are ignored. The byte after that becomes address bits 7..0. `mem_page` carries address bits 13..5 and `mem_byte` carries bits 4..0.
- R6: Each data byte received after the two address bytes gives exactly one `mem_wr_en` pulse of one cycle, with the byte on `mem_wdata` and the current counter on `mem_page`/`mem_byte`.
- R7: After each written byte only the byte field advances, wrapping from 31 to 0 without changing the page.
- R8: A read sends bytes fetched at the counter, most significant bit first, with `sda_oe` equal to the inverse of each bit. The line is released in the ninth clock.
- R9: Each read fetch advances the full 14-bit counter, wrapping from 3FFF to 0000.
- R10: A master acknowledge (line low in the ninth clock) starts the next byte. A master no-acknowledge sends the block to standby, with no further fetch and no driving of the line.
- R11: The counter keeps its value across stop and start, so a read issued straight after the address byte continues from it.
- R12: After reset `sda_oe`, `mem_wr_en` and `mem_rd_en` are low and the counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sel_i | input | 3 | Device select strap pins |
| sda_oe | output | 1 | Data line pull-down enable (1 drives the line low) |
| mem_page | output | 9 | Page field of the address counter |
| mem_byte | output | 5 | Byte-within-page field of the address counter |
| mem_wr_en | output | 1 | One-cycle write strobe to the array |
| mem_wdata | output | 8 | Byte to write, valid with `mem_wr_en` |
| mem_rd_en | output | 1 | One-cycle read strobe to the array |
| mem_rdata | input | 8 | Array read data, valid the cycle after `mem_rd_en` |

## Verification
The write strobe and the in-page wrap of the byte field land in the same cycle. This happens when a write burst crosses the last byte of a page. The bench starts a burst three bytes before the end of a page and compares every logged strobe address against the page and the byte offset modulo 32. In the same way, a read fetch at address 3FFF coincides with the full-counter wrap. The bench reads across that boundary and compares each returned byte with a pattern computed from the expected address.

// File: rtl/twslv_pkg.sv
package twslv_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_AHI,
    ST_ALO,
    ST_WDAT,
    ST_ACK,
    ST_RDAT,
    ST_MACK
  } st_e;
endpackage

// File: rtl/twslv_line_sync.sv
module twslv_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic scl, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_d  <= scl;
      sda_d  <= sda;
    end
  end

  assign scl       = scl_sh[STAGES-1];
  assign sda       = sda_sh[STAGES-1];
  assign scl_rise  = scl & ~scl_d;
  assign scl_fall  = ~scl & scl_d;
  // line changes while the clock stays high mark bus conditions
  assign start_det = scl & scl_d & sda_d & ~sda;
  assign stop_det  = scl & scl_d & ~sda_d & sda;
endmodule

// File: rtl/twslv_addr_ctr.sv
module twslv_addr_ctr #(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_hi,
  input  logic              ld_lo,
  input  logic [ADDR_W-9:0] hi_bits,
  input  logic [7:0]        lo_bits,
  input  logic              inc_page,
  input  logic              inc_full,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [BYTE_W-1:0] B_ONE = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
    end else if (ld_hi) begin
      addr[ADDR_W-1:8] <= hi_bits;
    end else if (ld_lo) begin
      addr[7:0] <= lo_bits;
    end else if (inc_full) begin
      addr <= addr + A_ONE;
    end else if (inc_page) begin
      addr[BYTE_W-1:0] <= addr[BYTE_W-1:0] + B_ONE;
    end
  end
endmodule

// File: rtl/twslv_engine.sv
module twslv_engine
  import twslv_pkg::*;
#(
  parameter logic [3:0] DEV_TYPE = 4'b1010
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             sda,
  input  logic             start_det,
  input  logic             stop_det,
  input  logic [SEL_W-1:0] sel,
  input  logic [7:0]       rdata,
  output logic             sda_oe,
  output logic [7:0]       data_q,
  output logic             ld_hi,
  output logic             ld_lo,
  output logic             inc_page,
  output logic             inc_full,
  output logic             wr_en,
  output logic             rd_en
);
  st_e        state, nxt;
  logic [2:0] cnt;
  logic [7:0] tx;
  logic       ack_drive, mack_ok, fetch_pend;
  logic [7:0] rx_byte;
  logic       dev_hit;

  assign rx_byte = {data_q[6:0], sda};
  assign dev_hit = (rx_byte[7:4] == DEV_TYPE) && (rx_byte[3:1] == sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      nxt        <= ST_IDLE;
      cnt        <= '0;
      tx         <= '0;
      data_q     <= '0;
      ack_drive  <= 1'b0;
      mack_ok    <= 1'b0;
      fetch_pend <= 1'b0;
      sda_oe     <= 1'b0;
      ld_hi      <= 1'b0;
      ld_lo      <= 1'b0;
      inc_page   <= 1'b0;
      inc_full   <= 1'b0;
      wr_en      <= 1'b0;
      rd_en      <= 1'b0;
    end else begin
      ld_hi      <= 1'b0;
      ld_lo      <= 1'b0;
      inc_page   <= 1'b0;
      inc_full   <= 1'b0;
      wr_en      <= 1'b0;
      rd_en      <= 1'b0;
      fetch_pend <= rd_en;
      if (fetch_pend) tx <= rdata;

      if (stop_det) begin
        state  <= ST_IDLE;
        sda_oe <= 1'b0;
      end else if (start_det) begin
        state     <= ST_DEV;
        cnt       <= '0;
        ack_drive <= 1'b0;
        sda_oe    <= 1'b0;
      end else begin
        case (state)
          ST_DEV, ST_AHI, ST_ALO, ST_WDAT: begin
            if (scl_rise) begin
              data_q <= rx_byte;
              cnt    <= cnt + 3'd1;
              if (cnt == 3'd7) begin
                state     <= ST_ACK;
                ack_drive <= 1'b0;
                case (state)
                  ST_DEV: begin
                    if (!dev_hit) begin
                      state <= ST_IDLE;
                    end else if (rx_byte[0]) begin
                      nxt      <= ST_RDAT;
                      rd_en    <= 1'b1;
                      inc_full <= 1'b1;
                    end else begin
                      nxt <= ST_AHI;
                    end
                  end
                  ST_AHI: begin
                    ld_hi <= 1'b1;
                    nxt   <= ST_ALO;
                  end
                  ST_ALO: begin
                    ld_lo <= 1'b1;
                    nxt   <= ST_WDAT;
                  end
                  default: begin
                    wr_en    <= 1'b1;
                    inc_page <= 1'b1;
                    nxt      <= ST_WDAT;
                  end
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (!ack_drive) begin
                ack_drive <= 1'b1;
                sda_oe    <= 1'b1;
              end else begin
                ack_drive <= 1'b0;
                state     <= nxt;
                cnt       <= '0;
                sda_oe    <= (nxt == ST_RDAT) ? ~tx[7] : 1'b0;
              end
            end
          end
          ST_RDAT: begin
            if (scl_fall) begin
              if (cnt == 3'd7) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                sda_oe <= ~tx[6];
                tx     <= {tx[6:0], 1'b0};
                cnt    <= cnt + 3'd1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack_ok <= ~sda;
              if (!sda) begin
                rd_en    <= 1'b1;
                inc_full <= 1'b1;
              end
            end
            if (scl_fall) begin
              if (mack_ok) begin
                state  <= ST_RDAT;
                cnt    <= '0;
                sda_oe <= ~tx[7];
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/twslv_top.sv
module twslv_top
  import twslv_pkg::*;
#(
  parameter int         ADDR_W      = 14,
  parameter int         BYTE_W      = 5,
  parameter logic [3:0] DEV_TYPE    = 4'b1010,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     scl_i,
  input  logic                     sda_i,
  input  logic [SEL_W-1:0]         sel_i,
  output logic                     sda_oe,
  output logic [ADDR_W-BYTE_W-1:0] mem_page,
  output logic [BYTE_W-1:0]        mem_byte,
  output logic                     mem_wr_en,
  output logic [7:0]               mem_wdata,
  output logic                     mem_rd_en,
  input  logic [7:0]               mem_rdata
);
  localparam int HI_W = ADDR_W - 8;

  logic              sda_w, scl_rise_w, scl_fall_w, start_det_w, stop_det_w;
  logic [7:0]        data_w;
  logic              ld_hi_w, ld_lo_w, inc_page_w, inc_full_w;
  logic [ADDR_W-1:0] addr_w;

  twslv_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .sda      (sda_w),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .start_det(start_det_w),
    .stop_det (stop_det_w)
  );

  twslv_engine #(.DEV_TYPE(DEV_TYPE)) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_rise (scl_rise_w),
    .scl_fall (scl_fall_w),
    .sda      (sda_w),
    .start_det(start_det_w),
    .stop_det (stop_det_w),
    .sel      (sel_i),
    .rdata    (mem_rdata),
    .sda_oe   (sda_oe),
    .data_q   (data_w),
    .ld_hi    (ld_hi_w),
    .ld_lo    (ld_lo_w),
    .inc_page (inc_page_w),
    .inc_full (inc_full_w),
    .wr_en    (mem_wr_en),
    .rd_en    (mem_rd_en)
  );

  twslv_addr_ctr #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_hi   (ld_hi_w),
    .ld_lo   (ld_lo_w),
    .hi_bits (data_w[HI_W-1:0]),
    .lo_bits (data_w),
    .inc_page(inc_page_w),
    .inc_full(inc_full_w),
    .addr    (addr_w)
  );

  assign mem_page  = addr_w[ADDR_W-1:BYTE_W];
  assign mem_byte  = addr_w[BYTE_W-1:0];
  assign mem_wdata = data_w;
endmodule

// File: rtl/twslv_checker.sv
module twslv_checker #(
  parameter int ADDR_W = 14,
  parameter int BYTE_W = 5
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     sda_oe,
  input logic                     mem_wr_en,
  input logic                     mem_rd_en,
  input logic                     scl_fall,
  input logic                     start_det,
  input logic                     stop_det,
  input logic [ADDR_W-BYTE_W-1:0] mem_page,
  input logic [BYTE_W-1:0]        mem_byte
);
  localparam logic [ADDR_W-1:0] A_ONE = 1;
  localparam logic [BYTE_W-1:0] B_ONE = 1;

  logic [ADDR_W-1:0] cur_addr;
  assign cur_addr = {mem_page, mem_byte};

  // R4: the pull-down only moves after a clock fall or a bus condition
  a_r4_oe_moves_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> ($past(scl_fall) || $past(start_det) || $past(stop_det)));

  // R6: write strobe lasts one cycle and never overlaps a fetch
  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> !mem_wr_en);
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_wr_en && mem_rd_en));

  // R7: after a write only the byte field moves, wrapping inside the page
  a_r7_page_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |=> (mem_page == $past(mem_page)) && (mem_byte == $past(mem_byte) + B_ONE));

  // R9: a fetch advances the whole counter by one
  a_r9_full_incr: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en |=> (cur_addr == $past(cur_addr) + A_ONE));
endmodule

bind twslv_top twslv_checker #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .mem_wr_en(mem_wr_en),
  .mem_rd_en(mem_rd_en),
  .scl_fall (scl_fall_w),
  .start_det(start_det_w),
  .stop_det (stop_det_w),
  .mem_page (mem_page),
  .mem_byte (mem_byte)
);

// File: tb/twslv_top_tb.sv
`timescale 1ns/1ps
module twslv_top_tb;
  localparam int Q      = 5;
  localparam int WD_CYC = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [2:0] sel_m = 3'd5;
  logic       sda_oe;
  logic [8:0] mem_page;
  logic [4:0] mem_byte;
  logic       mem_wr_en, mem_rd_en;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = 8'h00;
  wire        sda_bus = sda_m & ~sda_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [13:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  int          wr_n = 0;

  always #4 clk = ~clk;

  twslv_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sel_i(sel_m),
    .sda_oe(sda_oe), .mem_page(mem_page), .mem_byte(mem_byte),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata), .mem_rd_en(mem_rd_en),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] pat(input logic [13:0] a);
    return a[7:0] ^ {a[13:8], 2'b11};
  endfunction

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= pat({mem_page, mem_byte});
    if (mem_wr_en && wr_n < 64) begin
      wlog_a[wr_n] <= {mem_page, mem_byte};
      wlog_d[wr_n] <= mem_wdata;
      wr_n <= wr_n + 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output bit acked, output bit rel);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(2);
    acked = ~sda_bus;
    tick(Q - 2);
    scl_m = 1'b0; tick(Q);
    rel = sda_bus;
  endtask

  task automatic get_byte(output logic [7:0] b, input bit mack, output bit nine);
    b = '0;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q);
      scl_m = 1'b1; tick(2);
      b[i] = sda_bus;
      tick(Q - 2);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = ~mack; tick(Q);
    scl_m = 1'b1; tick(2);
    nine = sda_bus;
    tick(Q - 2);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack, rel, nine;
    logic [7:0] d;
    int base, lows;

    tick(4);
    rst_n = 1'b1;
    tick(3);
    // R12: quiet after reset
    chk("R12 sda_oe", int'(sda_oe), 0);
    chk("R12 strobes", int'({mem_wr_en, mem_rd_en}), 0);
    chk("R12 counter", int'({mem_page, mem_byte}), 0);

    // R2 R3 R5: sweep every first byte against straps 101
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      bit exp;
      b   = 8'(v);
      exp = (b[7:4] == 4'hA) && (b[3:1] == 3'd5);
      bus_start();
      put_byte(b, ack, rel);
      chk($sformatf("R2 R3 ack for %02h", b), int'(ack), int'(exp));
      if (ack && b[0]) get_byte(d, 1'b0, nine);
      bus_stop();
    end

    // R2: after a mismatch a matching byte without a new start is ignored
    bus_start();
    put_byte(8'hBA, ack, rel);
    chk("R2 wrong type", int'(ack), 0);
    put_byte(8'hAA, ack, rel);
    chk("R2 ignored until start", int'(ack), 0);
    bus_stop();

    // R3: each strap value, matching and neighbouring select code
    for (int s = 0; s < 8; s++) begin
      sel_m = 3'(s);
      bus_start();
      put_byte({4'hA, 3'(s), 1'b0}, ack, rel);
      chk($sformatf("R3 sel %0d hit", s), int'(ack), 1);
      bus_stop();
      bus_start();
      put_byte({4'hA, 3'(s) ^ 3'd2, 1'b0}, ack, rel);
      chk($sformatf("R3 sel %0d miss", s), int'(ack), 0);
      bus_stop();
    end
    sel_m = 3'd5;

    // R5 R4: address load, top bits of high byte ignored
    bus_start();
    put_byte(8'hAA, ack, rel);
    chk("R4 dev ack", int'(ack), 1);
    chk("R4 dev release", int'(rel), 1);
    put_byte(8'hD2, ack, rel);
    chk("R4 hi ack", int'(ack), 1);
    put_byte(8'h3D, ack, rel);
    chk("R4 lo ack", int'(ack), 1);
    chk("R5 page field", int'(mem_page), int'(14'h123D >> 5));
    chk("R5 byte field", int'(mem_byte), int'(14'h123D & 14'h1F));
    // R6 R7: burst across the page end
    base = wr_n;
    for (int i = 0; i < 5; i++) begin
      put_byte(8'(8'h50 + i), ack, rel);
      chk("R4 data ack", int'(ack), 1);
      chk("R4 data release", int'(rel), 1);
    end
    bus_stop();
    chk("R6 strobe count", wr_n - base, 5);
    for (int i = 0; i < 5; i++) begin
      int ea;
      ea = (int'(14'h123D) & 32'h3FE0) | ((int'(14'h123D) + i) & 31);
      chk($sformatf("R7 write addr %0d", i), int'(wlog_a[base + i]), ea);
      chk($sformatf("R6 write data %0d", i), int'(wlog_d[base + i]), 32'h50 + i);
    end

    // R8 R9: random read across the top of the address space
    bus_start();
    put_byte(8'hAA, ack, rel);
    put_byte(8'h3F, ack, rel);
    put_byte(8'hFE, ack, rel);
    bus_start();
    put_byte(8'hAB, ack, rel);
    chk("R5 read ack", int'(ack), 1);
    get_byte(d, 1'b1, nine);
    chk("R8 byte 3FFE", int'(d), int'(pat(14'h3FFE)));
    get_byte(d, 1'b1, nine);
    chk("R9 byte 3FFF", int'(d), int'(pat(14'h3FFF)));
    get_byte(d, 1'b0, nine);
    chk("R9 wrap 0000", int'(d), int'(pat(14'h0000)));
    chk("R8 ninth released", int'(nine), 1);
    bus_stop();

    // R11 R10: current-address read, then clocks after no-acknowledge
    bus_start();
    put_byte(8'hAB, ack, rel);
    get_byte(d, 1'b0, nine);
    chk("R11 continue 0001", int'(d), int'(pat(14'h0001)));
    lows = 0;
    for (int i = 0; i < 9; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(2);
      if (!sda_bus) lows++;
      tick(Q - 2);
      scl_m = 1'b0;
    end
    tick(Q);
    chk("R10 silent after nack", lows, 0);
    bus_stop();
    bus_start();
    put_byte(8'hAB, ack, rel);
    get_byte(d, 1'b0, nine);
    chk("R10 no extra fetch", int'(d), int'(pat(14'h0002)));
    bus_stop();

    // R1: stop in the middle of the high address byte
    bus_start();
    put_byte(8'hAA, ack, rel);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    bus_stop();
    chk("R1 released after stop", int'(sda_oe), 0);
    bus_start();
    put_byte(8'hAB, ack, rel);
    chk("R1 restart ack", int'(ack), 1);
    get_byte(d, 1'b0, nine);
    chk("R1 counter kept", int'(d), int'(pat(14'h0003)));
    bus_stop();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule